// File: doc/BRIEF.md
# Auto-Reload Timer/Counter with Capture

This block is a byte-programmable up-counter, 16 bits wide by default, paired with a second register of the same width. The second register serves two purposes. It holds the value that is loaded back into the count after a wrap, and it receives a snapshot of the count when an external capture event occurs. Software selects the count source through a control byte. In timer mode the count advances on every clock. In external-count mode it advances on each falling edge of a pin, which is synchronized and checked once per clock, and only while a gate input is high.

Every wrap from the all-ones value produces a one-cycle pulse on a registered output, which can drive a serial port's bit-rate logic. The same wrap sets a sticky flag. A capture sets its own sticky flag. A cleared run bit freezes the count. All registers sit behind a single address bus. Writes take effect on the clock edge. Read data is registered and appears one cycle after the address.

Top module: `reload_capture_timer`

## Requirements
- R1: After synchronous reset every register reads 0, `ovf_o` is 0 and `rd_data` is 0.
- R2: Address map with NBYTE=2. Addresses 0 and 1 are the count low and high bytes. Addresses 2 and 3 are the reload/capture low and high bytes. Address 4 is the control byte. Control bits are: bit 0 run, bit 1 external-count select, bit 2 auto-reload, bit 3 capture enable, bit 4 wrap flag, bit 5 capture flag. Bits 6 and 7 read 0, and unmapped addresses read 0. `rd_data` shows the register selected by `addr` on the previous clock, with the value it held before that edge.
- R3: With run=1 and external select=0, the count increases by one on every clock.
- R4: With run=1 and external select=1, the count increases by one for each falling edge of `ext_i`. The edge is seen through two synchronizer flops plus one history flop, so a 1-to-0 change applied before edge k increments the count at edge k+2. The count does not change at that edge unless `gate_i` is high.
- R5: With run=0 the count never changes, except through software writes.
- R6: When the count is all ones and an increment occurs, the count becomes 0 if auto-reload=0. In the same edge `ovf_o` is high for that cycle and the wrap flag is set.
- R7: With auto-reload=1, a wrap loads the reload/capture register into the count instead of 0.
- R8: With capture enable=1, a rising edge on `cap_i` (same synchronizer latency as R4) copies the count value held before that edge into the reload/capture register and sets the capture flag. Counting continues unaffected.
- R9: The wrap and capture flags stay set until a control write carries 0 in their bit. Writing 1 leaves them unchanged. A set event in the same cycle as a clear wins.
- R10: A software write to a count byte replaces that byte and cancels that cycle's increment. A capture takes precedence over a software write to the reload/capture register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | ADDR_W | Register address for write and read |
| wr_data | input | DATA_W | Write data byte |
| rd_data | output | DATA_W | Registered read data |
| ext_i | input | 1 | External count input, falling edges counted |
| gate_i | input | 1 | Enables external counting when high |
| cap_i | input | 1 | Capture strobe, rising edge active |
| ovf_o | output | 1 | One-cycle pulse on every wrap |

## Verification
The bench builds the block with DATA_W=8 and NBYTE=2, giving a 16-bit count at the default width. Preloading the count close to all ones, and loading the reload register with 0xFF00, brings wraps into reach within a few hundred cycles. This covers both the zero-restart case and the auto-reload case many times over. Random phases then mix byte writes, gate changes and capture strobes so that the precedence rules and the flag set-versus-clear collisions all occur.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CB_RUN   = 0;
  localparam int CB_EXT   = 1;
  localparam int CB_ARL   = 2;
  localparam int CB_CAPEN = 3;
  localparam int CB_OVF   = 4;
  localparam int CB_CAPF  = 5;

  typedef struct packed {
    logic capf;
    logic ovf;
    logic capen;
    logic arl;
    logic ext;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter bit RISE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic evt
);
  // sh[0], sh[1]: synchronizer; sh[2]: history for edge detection
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end

  generate
    if (RISE) begin : g_rise
      assign evt = sh[1] & ~sh[2];
    end else begin : g_fall
      assign evt = ~sh[1] & sh[2];
    end
  endgenerate

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt); // R4
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTE  = 2,
  parameter int ADDR_W = 3,
  localparam int CNT_W = DATA_W * NBYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_evt,
  input  logic              gate_i,
  input  logic              cap_evt,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rld_q,
  output tmr_ctrl_t         ctrl_q,
  output logic              ovf_q
);
  localparam int CTRL_A = 2 * NBYTE;

  logic [CNT_W-1:0] cnt_nxt, rld_nxt;
  tmr_ctrl_t        ctrl_nxt;
  logic             cnt_wr, inc, wrap, cap_hit, ctrl_wr;

  always_comb begin
    cnt_nxt = cnt_q;
    rld_nxt = rld_q;
    cnt_wr  = 1'b0;
    for (int i = 0; i < NBYTE; i++) begin
      if (wr_en && wr_addr == ADDR_W'(i)) begin
        cnt_nxt[i*DATA_W +: DATA_W] = wr_data;
        cnt_wr = 1'b1;
      end
      if (wr_en && wr_addr == ADDR_W'(NBYTE + i))
        rld_nxt[i*DATA_W +: DATA_W] = wr_data;
    end
    inc     = ctrl_q.run && (ctrl_q.ext ? (gate_i && cnt_evt) : 1'b1);
    wrap    = inc && !cnt_wr && (cnt_q == '1);
    cap_hit = ctrl_q.capen && cap_evt;
    if (!cnt_wr && inc)
      cnt_nxt = wrap ? (ctrl_q.arl ? rld_q : '0) : cnt_q + CNT_W'(1);
    if (cap_hit)
      rld_nxt = cnt_q;
  end

  always_comb begin
    ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_A));
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) begin
      ctrl_nxt.run   = wr_data[CB_RUN];
      ctrl_nxt.ext   = wr_data[CB_EXT];
      ctrl_nxt.arl   = wr_data[CB_ARL];
      ctrl_nxt.capen = wr_data[CB_CAPEN];
      ctrl_nxt.ovf   = ctrl_q.ovf  & wr_data[CB_OVF];
      ctrl_nxt.capf  = ctrl_q.capf & wr_data[CB_CAPF];
    end
    if (wrap)    ctrl_nxt.ovf  = 1'b1;
    if (cap_hit) ctrl_nxt.capf = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      rld_q  <= rld_nxt;
      ctrl_q <= ctrl_nxt;
      ovf_q  <= wrap;
    end
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && !ctrl_q.ext && !cnt_wr && cnt_q != '1)
      |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ext && !gate_i && !cnt_wr) |=> $stable(cnt_q)); // R4
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !cnt_wr) |=> $stable(cnt_q)); // R5
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> ctrl_q.ovf); // R6
  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> cnt_q == ($past(ctrl_q.arl) ? $past(rld_q) : '0)); // R7
  AST_CAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> (ctrl_q.capf && rld_q == $past(cnt_q))); // R8
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTE  = 2,
  parameter int ADDR_W = 3,
  localparam int CNT_W = DATA_W * NBYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  rld,
  input  tmr_ctrl_t         ctrl,
  output logic [DATA_W-1:0] rd_q
);
  localparam int CTRL_A = 2 * NBYTE;
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NBYTE; i++) begin
      if (rd_addr == ADDR_W'(i))         sel = cnt[i*DATA_W +: DATA_W];
      if (rd_addr == ADDR_W'(NBYTE + i)) sel = rld[i*DATA_W +: DATA_W];
    end
    if (rd_addr == ADDR_W'(CTRL_A)) sel = DATA_W'(ctrl);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= sel;
  end
endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTE  = 2,
  localparam int ADDR_W = $clog2(2 * NBYTE + 1),
  localparam int CNT_W  = DATA_W * NBYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_i,
  input  logic              gate_i,
  input  logic              cap_i,
  output logic              ovf_o
);
  logic             fall_evt, cap_evt;
  logic [CNT_W-1:0] cnt, rld;
  tmr_ctrl_t        ctrl;

  tmr_edge_sync #(.RISE(1'b0)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_i), .evt(fall_evt)
  );

  tmr_edge_sync #(.RISE(1'b1)) u_cap_sync (
    .clk(clk), .rst(rst), .din(cap_i), .evt(cap_evt)
  );

  tmr_core #(.DATA_W(DATA_W), .NBYTE(NBYTE), .ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .cnt_evt(fall_evt), .gate_i(gate_i), .cap_evt(cap_evt),
    .cnt_q(cnt), .rld_q(rld), .ctrl_q(ctrl), .ovf_q(ovf_o)
  );

  tmr_rdmux #(.DATA_W(DATA_W), .NBYTE(NBYTE), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(addr), .cnt(cnt), .rld(rld), .ctrl(ctrl),
    .rd_q(rd_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !ovf_o)); // R1
endmodule

// File: tb/sim_reload_capture_timer.sv
module sim_reload_capture_timer;
  localparam int DW = 8;
  localparam int NB = 2;
  localparam int AW = $clog2(2 * NB + 1);
  localparam int CW = DW * NB;
  localparam longint MAXV = (64'd1 << CW) - 1;
  localparam longint BMASK = (64'd1 << DW) - 1;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic ext = 1'b0, gate = 1'b0, cap = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic ovf_o;

  always #10 clk = ~clk;

  reload_capture_timer #(.DATA_W(DW), .NBYTE(NB)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wdata),
    .rd_data(rd_data), .ext_i(ext), .gate_i(gate), .cap_i(cap), .ovf_o(ovf_o)
  );

  longint m_cnt = 0, m_rld = 0, m_rd = 0;
  bit m_run, m_ext, m_arl, m_capen, m_ovf, m_capf, m_pulse;
  bit eh[$] = '{0, 0, 0};
  bit ch[$] = '{0, 0, 0};
  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  function automatic longint put_byte(longint v, int idx, longint b);
    return (v & ~(BMASK << (DW * idx))) | ((b & BMASK) << (DW * idx));
  endfunction

  task automatic model_edge();
    longint oc, orl;
    bit fall, rise, inc, caph, sov;
    int a;
    if (rst) begin
      m_cnt = 0; m_rld = 0; m_rd = 0;
      {m_run, m_ext, m_arl, m_capen, m_ovf, m_capf, m_pulse} = '0;
      eh = '{0, 0, 0}; ch = '{0, 0, 0};
      return;
    end
    oc = m_cnt; orl = m_rld; a = int'(addr);
    if (a < NB)            m_rd = (oc >> (DW * a)) & BMASK;
    else if (a < 2 * NB)   m_rd = (orl >> (DW * (a - NB))) & BMASK;
    else if (a == 2 * NB)  m_rd = {m_capf, m_ovf, m_capen, m_arl, m_ext, m_run};
    else                   m_rd = 0;
    fall = (eh[0] == 1) && (eh[1] == 0);
    rise = (ch[0] == 0) && (ch[1] == 1);
    eh.push_back(ext); void'(eh.pop_front());
    ch.push_back(cap); void'(ch.pop_front());
    inc  = m_run && (m_ext ? (gate && fall) : 1'b1);
    caph = m_capen && rise;
    sov  = 0;
    if (wr_en && a < NB) m_cnt = put_byte(oc, a, wdata);
    else if (inc) begin
      if (oc == MAXV) begin m_cnt = m_arl ? orl : 0; sov = 1; end
      else m_cnt = oc + 1;
    end
    m_pulse = sov;
    if (caph) m_rld = oc;
    else if (wr_en && a >= NB && a < 2 * NB) m_rld = put_byte(orl, a - NB, wdata);
    if (wr_en && a == 2 * NB) begin
      m_run = wdata[0]; m_ext = wdata[1]; m_arl = wdata[2]; m_capen = wdata[3];
      m_ovf  = sov  | (m_ovf  & wdata[4]);
      m_capf = caph | (m_capf & wdata[5]);
    end else begin
      m_ovf  = m_ovf | sov;
      m_capf = m_capf | caph;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_edge();
    checks += 2;
    if (rd_data !== DW'(m_rd)) begin
      errors++;
      $display("FAIL %s: rd_data addr-prev actual=%h expected=%h at %0t", req, rd_data, DW'(m_rd), $time);
    end
    if (ovf_o !== m_pulse) begin
      errors++;
      $display("FAIL %s: ovf_o actual=%b expected=%b at %0t", req, ovf_o, m_pulse, $time);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      addr = AW'($urandom_range(0, 2 * NB));
      tick();
    end
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    repeat (3) tick();
    rst = 1'b0;
    idle(5);
    // R2: byte map and registered read, counter stopped (R5)
    req = "R2";
    wr(0, 8'h34); wr(1, 8'h12); wr(2, 8'hCD); wr(3, 8'hAB);
    for (int a = 0; a < 7; a++) begin addr = AW'(a); tick(); end
    // R3: timer mode
    req = "R3";
    wr(4, 8'h01);
    idle(20);
    // R6: free-running wrap to zero
    req = "R6";
    wr(1, 8'hFF); wr(0, 8'hF0);
    idle(40);
    // R7: auto-reload from 0xFF00
    req = "R7";
    wr(2, 8'h00); wr(3, 8'hFF); wr(4, 8'h35);
    idle(600);
    // R9: flags sticky, writing 1 keeps, writing 0 clears
    req = "R9";
    wr(4, 8'h30); idle(3);
    wr(4, 8'h00); idle(3);
    wr(1, 8'hFF); wr(0, 8'hFE); wr(4, 8'h01); idle(4);
    wr(4, 8'h21); idle(3);
    // R4: external falling-edge counting with gate
    req = "R4";
    wr(4, 8'h03);
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 2) == 0) ext = ~ext;
      if ($urandom_range(0, 30) == 0) gate = ~gate;
      idle(1);
    end
    // R8: capture while counting, with reload writes (R10)
    req = "R8";
    wr(4, 8'h09);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 5) == 0) cap = ~cap;
      if ($urandom_range(0, 15) == 0) wr($urandom_range(2, 3), $urandom_range(0, 255));
      else idle(1);
    end
    // R5: stopped counter ignores edges and clock
    req = "R5";
    wr(4, 8'h02);
    for (int i = 0; i < 120; i++) begin
      ext = $urandom_range(0, 1); gate = $urandom_range(0, 1);
      idle(1);
    end
    // R10: everything mixed, including count writes colliding with increments
    req = "R10";
    for (int i = 0; i < 2000; i++) begin
      ext = $urandom_range(0, 1); gate = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 4) == 0) cap = ~cap;
      if ($urandom_range(0, 7) == 0) begin
        int a;
        a = $urandom_range(0, 2 * NB);
        if (a == 2 * NB) wr(a, $urandom_range(0, 255) | 1);
        else wr(a, ($urandom_range(0, 1) != 0) ? 8'hFF : $urandom_range(0, 255));
      end else idle(1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s: watchdog actual=running expected=finished", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule